// File: doc/BRIEF.md
# Programmable-Sense Pin Interrupt Controller

This block watches up to 32 external interrupt pins. Each pin passes through a synchronizer into the block clock domain. A per-line sense code chooses how the pin is watched: while it is low, while it is high, on a rising edge, on a falling edge, or on either edge. A hit sets a sticky detect bit for that line. Software clears the bit by writing a one to it.

Each line also has an enable bit. Software sets it by writing ones to one register and clears it by writing ones to another, so no read-modify-write of a shared mask is needed. Each interrupt output is the line's detect bit gated by its enable bit. The same gated vector can be read back as a request status word. A monitor word shows the synchronized pin levels.

All access goes through a simple 32-bit register port with a byte address. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, all detect bits, enable bits and per-line configuration words are zero, and every interrupt output is low.
- R2: Each pin passes through a two-stage synchronizer. Reading byte offset 0x104 returns the synchronized levels, one bit per line. A pin change made between two clock edges shows up there after the second following edge.
- R3: Line n has a full 32-bit configuration word at byte offset 0x180 + 4*n that reads back as written. Its bits [5:0] are the sense code. Writes to slots for lines at or above the configured line count are dropped, and those slots read zero.
- R4: Sense code 0x01 detects a low level and 0x02 detects a high level. In these modes the detect bit is set on every cycle the level is active, so a clear written while the level persists leaves the bit set.
- R5: Sense code 0x08 detects a rising edge, 0x04 a falling edge, and 0x0C either edge. Each edge is found by comparing the synchronized level with the synchronized level of the previous cycle.
- R6: A sense code of 0x00, or any code not listed in R4 and R5, sets no detect bit.
- R7: The detect word at byte offset 0x100 is write-one-to-clear, and zero bits in the written data leave detect bits unchanged. If a detection and a clear of the same bit fall in the same cycle, the bit stays set.
- R8: Writing ones to offset 0x08 sets those enable bits. Writing ones to offset 0x04 clears them. Reading 0x04 returns the enable mask, and reading 0x08 returns zero.
- R9: Interrupt output n, and bit n of the read-only request word at offset 0x00, equal detect bit n AND enable bit n. Writes to offsets 0x00 and 0x104 have no effect.
- R10: Reads of unmapped or unaligned offsets return zero, and bits above the configured line count read zero in every status word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_LINES | Raw external interrupt pins |
| busWe | input | 1 | Write strobe, sampled on the rising clock edge |
| busAddr | input | 9 | Byte address of the register access |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| irqOut | output | NUM_LINES | Per-line interrupt outputs, detect gated by enable |

## Verification
The bench builds the controller with NUM_LINES set to 12 rather than the full 32. This puts configuration slots above the last line and status bits above the line count within reach, so the bench can check that writes to them are dropped and that they read zero. The random phase includes configuration slot indices up to 15 and invalid sense codes. It also toggles pins while lines are in level modes, so the bench sees set-and-clear collisions in the same cycle and clears that arrive while a level is still active.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 9;
  localparam int MAX_LINES = 32;
  localparam int SENSE_W   = 6;
  localparam int IDX_W     = $clog2(MAX_LINES);

  // register offsets (byte addresses)
  localparam logic [ADDR_W-1:0] OFS_REQ    = 9'h000;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR = 9'h004;
  localparam logic [ADDR_W-1:0] OFS_EN_SET = 9'h008;
  localparam logic [ADDR_W-1:0] OFS_DET    = 9'h100;
  localparam logic [ADDR_W-1:0] OFS_MON    = 9'h104;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_OFF  = 6'h00,
    SENSE_LOW  = 6'h01,
    SENSE_HIGH = 6'h02,
    SENSE_FALL = 6'h04,
    SENSE_RISE = 6'h08,
    SENSE_BOTH = 6'h0C
  } sense_e;

  // strobes from the bus decoder to the datapath
  typedef struct packed {
    logic              enSet;
    logic              enClr;
    logic              detClr;
    logic              cfgWr;
    logic [IDX_W-1:0]  cfgIdx;
    logic [DATA_W-1:0] wdata;
  } strobe_t;

endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stageReg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : gStage
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageReg[s] <= '0;
          else       stageReg[s] <= din;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageReg[s] <= '0;
          else       stageReg[s] <= stageReg[s-1];
        end
      end
    end
  endgenerate

  assign dout = stageReg[STAGES-1];

endmodule

// File: rtl/pin_irq_dp.sv
module pin_irq_dp
  import pin_irq_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_LINES-1:0]          pinIn,
  input  strobe_t                       strb,
  output logic [NUM_LINES-1:0]          monitor,
  output logic [NUM_LINES-1:0]          detStat,
  output logic [NUM_LINES-1:0]          enMask,
  output logic [NUM_LINES-1:0]          irqReq,
  output logic [NUM_LINES*DATA_W-1:0]   cfgFlat
);

  logic [NUM_LINES-1:0] synced;
  logic [NUM_LINES-1:0] prevReg;
  logic [NUM_LINES-1:0] hitVec;
  logic [NUM_LINES-1:0] lineMask;
  logic [NUM_LINES-1:0] clrVec;
  logic [NUM_LINES-1:0] setEnVec;
  logic [NUM_LINES-1:0] clrEnVec;
  logic [NUM_LINES-1:0] detReg;
  logic [NUM_LINES-1:0] enReg;
  logic [DATA_W-1:0]    cfgReg [NUM_LINES];

  pin_irq_sync #(
    .WIDTH (NUM_LINES),
    .STAGES(SYNC_STAGES)
  ) uSync (
    .clk (clk),
    .rstN(rstN),
    .din (pinIn),
    .dout(synced)
  );

  // previous synchronized sample, edge reference
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevReg <= '0;
    else       prevReg <= synced;
  end

  assign lineMask = strb.wdata[NUM_LINES-1:0];
  assign clrVec   = strb.detClr ? lineMask : '0;
  assign setEnVec = strb.enSet  ? lineMask : '0;
  assign clrEnVec = strb.enClr  ? lineMask : '0;

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : gLine
      sense_e senseCode;
      logic   lineHit;
      logic   lineArmed;

      assign senseCode = sense_e'(cfgReg[i][SENSE_W-1:0]);

      always_comb begin
        lineHit   = 1'b0;
        lineArmed = 1'b1;
        case (senseCode)
          SENSE_LOW:  lineHit = !synced[i];
          SENSE_HIGH: lineHit = synced[i];
          SENSE_FALL: lineHit = prevReg[i] && !synced[i];
          SENSE_RISE: lineHit = !prevReg[i] && synced[i];
          SENSE_BOTH: lineHit = prevReg[i] ^ synced[i];
          default:    lineArmed = 1'b0;
        endcase
      end

      assign hitVec[i] = lineHit;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          cfgReg[i] <= '0;
        else if (strb.cfgWr && strb.cfgIdx == IDX_W'(i))
          cfgReg[i] <= strb.wdata;
      end

      assign cfgFlat[i*DATA_W +: DATA_W] = cfgReg[i];

      // R4: an active high level is latched on the next edge
      assert_level_high_R4: assert property (@(posedge clk) disable iff (!rstN)
        (senseCode == SENSE_HIGH && synced[i]) |=> detReg[i]);

      // R4: an active low level is latched on the next edge
      assert_level_low_R4: assert property (@(posedge clk) disable iff (!rstN)
        (senseCode == SENSE_LOW && !synced[i]) |=> detReg[i]);

      // R6: an unarmed line never raises its detect bit
      assert_idle_line_R6: assert property (@(posedge clk) disable iff (!rstN)
        (!lineArmed && !detReg[i]) |=> !detReg[i]);
    end
  endgenerate

  // detection wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) detReg <= '0;
    else       detReg <= (detReg & ~clrVec) | hitVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enReg <= '0;
    else       enReg <= (enReg & ~clrEnVec) | setEnVec;
  end

  assign monitor = synced;
  assign detStat = detReg;
  assign enMask  = enReg;
  assign irqReq  = detReg & enReg;

  // R7: a detect bit only falls when a clear named it
  assert_det_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(detReg) & ~detReg) & ~$past(clrVec)) == '0));

  // R8: enable-set leaves every named bit high
  assert_en_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.enSet |=> ((enReg & $past(lineMask)) == $past(lineMask)));

  // R8: enable-clear leaves every named bit low
  assert_en_clr_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.enClr |=> ((enReg & $past(lineMask)) == '0));

endmodule

// File: rtl/pin_irq_ctl.sv
module pin_irq_ctl
  import pin_irq_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                          busWe,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [DATA_W-1:0]             busWrData,
  input  logic [NUM_LINES-1:0]          detStat,
  input  logic [NUM_LINES-1:0]          enMask,
  input  logic [NUM_LINES-1:0]          irqReq,
  input  logic [NUM_LINES-1:0]          monitor,
  input  logic [NUM_LINES*DATA_W-1:0]   cfgFlat,
  output strobe_t                       strb,
  output logic [DATA_W-1:0]             busRdData
);

  localparam int CNT_W = IDX_W + 1;

  logic             aligned;
  logic             inCfgWin;
  logic [IDX_W-1:0] cfgIdx;
  logic             cfgHit;

  assign aligned  = (busAddr[1:0] == 2'b00);
  assign inCfgWin = (busAddr[ADDR_W-1 -: 2] == 2'b11);
  assign cfgIdx   = busAddr[2 +: IDX_W];
  assign cfgHit   = aligned && inCfgWin && ({1'b0, cfgIdx} < CNT_W'(NUM_LINES));

  always_comb begin
    strb        = '0;
    strb.wdata  = busWrData;
    strb.cfgIdx = cfgIdx;
    strb.enSet  = busWe && (busAddr == OFS_EN_SET);
    strb.enClr  = busWe && (busAddr == OFS_EN_CLR);
    strb.detClr = busWe && (busAddr == OFS_DET);
    strb.cfgWr  = busWe && cfgHit;
  end

  always_comb begin
    busRdData = '0;
    if (cfgHit) begin
      for (int l = 0; l < NUM_LINES; l++) begin
        if (cfgIdx == IDX_W'(l)) busRdData = cfgFlat[l*DATA_W +: DATA_W];
      end
    end else begin
      case (busAddr)
        OFS_REQ:    busRdData = DATA_W'(irqReq);
        OFS_EN_CLR: busRdData = DATA_W'(enMask);
        OFS_DET:    busRdData = DATA_W'(detStat);
        OFS_MON:    busRdData = DATA_W'(monitor);
        default:    busRdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] pinIn,
  input  logic                 busWe,
  input  logic [8:0]           busAddr,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  output logic [NUM_LINES-1:0] irqOut
);

  strobe_t                       strb;
  logic [NUM_LINES-1:0]          monitor;
  logic [NUM_LINES-1:0]          detStat;
  logic [NUM_LINES-1:0]          enMask;
  logic [NUM_LINES-1:0]          irqReq;
  logic [NUM_LINES*DATA_W-1:0]   cfgFlat;

  pin_irq_ctl #(
    .NUM_LINES(NUM_LINES)
  ) uCtl (
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .detStat  (detStat),
    .enMask   (enMask),
    .irqReq   (irqReq),
    .monitor  (monitor),
    .cfgFlat  (cfgFlat),
    .strb     (strb),
    .busRdData(busRdData)
  );

  pin_irq_dp #(
    .NUM_LINES  (NUM_LINES),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  (pinIn),
    .strb   (strb),
    .monitor(monitor),
    .detStat(detStat),
    .enMask (enMask),
    .irqReq (irqReq),
    .cfgFlat(cfgFlat)
  );

  assign irqOut = irqReq;

endmodule

// File: tb/tb_pin_irq_ctrl.sv
`timescale 1ns/1ps
module tb_pin_irq_ctrl;

  localparam int N = 12;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] pins = '0;
  logic         busWe = 1'b0;
  logic [8:0]   busAddr = '0;
  logic [31:0]  busWrData = '0;
  logic [31:0]  busRdData;
  logic [N-1:0] irqOut;

  pin_irq_ctrl #(.NUM_LINES(N)) dut (
    .clk(clk), .rstN(rstN), .pinIn(pins), .busWe(busWe),
    .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .irqOut(irqOut)
  );

  always #2 clk = ~clk;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  // reference model built from the requirements
  logic [N-1:0] m1, m2, mPrev, mDet, mEn;
  logic [31:0]  mCfg [N];

  function automatic logic senseHit(logic [5:0] s, logic cur, logic prv);
    case (s)
      6'h01:   return !cur;
      6'h02:   return cur;
      6'h04:   return prv && !cur;
      6'h08:   return !prv && cur;
      6'h0C:   return prv != cur;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic cfgSlot(logic [8:0] a);
    return a[8:7] == 2'b11 && a[1:0] == 2'b00 && int'(a[6:2]) < N;
  endfunction

  always @(posedge clk or negedge rstN) begin : model
    logic [N-1:0] hit;
    logic [N-1:0] clr;
    if (!rstN) begin
      m1 <= '0; m2 <= '0; mPrev <= '0; mDet <= '0; mEn <= '0;
      for (int i = 0; i < N; i++) mCfg[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) hit[i] = senseHit(mCfg[i][5:0], m2[i], mPrev[i]);
      clr = (busWe && busAddr == 9'h100) ? busWrData[N-1:0] : '0;
      m1 <= pins; m2 <= m1; mPrev <= m2;
      mDet <= (mDet & ~clr) | hit;
      if (busWe && busAddr == 9'h008) mEn <= mEn | busWrData[N-1:0];
      if (busWe && busAddr == 9'h004) mEn <= mEn & ~busWrData[N-1:0];
      if (busWe && cfgSlot(busAddr)) mCfg[busAddr[6:2]] <= busWrData;
    end
  end

  function automatic logic [31:0] expRead(logic [8:0] a);
    if (cfgSlot(a)) return mCfg[a[6:2]];
    case (a)
      9'h000:  return 32'(mDet & mEn);
      9'h004:  return 32'(mEn);
      9'h100:  return 32'(mDet);
      9'h104:  return 32'(m2);
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdConst(logic [8:0] a, logic [31:0] exp, string tag);
    busWe = 1'b0; busAddr = a;
    #1;
    check(tag, busRdData, exp);
  endtask

  task automatic rdModel(logic [8:0] a, string tag);
    busWe = 1'b0; busAddr = a;
    #1;
    check(tag, busRdData, expRead(a));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string tagFor(logic [8:0] a);
    if (a[8:7] == 2'b11) return "R3 cfg read";
    case (a)
      9'h000:  return "R9 request read";
      9'h004:  return "R8 enable read";
      9'h008:  return "R8 set reg reads zero";
      9'h100:  return "R7 detect read";
      9'h104:  return "R2 monitor read";
      default: return "R10 unmapped read";
    endcase
  endfunction

  function automatic logic [5:0] pickSense();
    case ($urandom_range(0, 7))
      0: return 6'h00; 1: return 6'h01; 2: return 6'h02; 3: return 6'h04;
      4: return 6'h08; 5: return 6'h0C; 6: return 6'h03; default: return 6'h10;
    endcase
  endfunction

  function automatic logic [8:0] pickReadAddr();
    case ($urandom_range(0, 8))
      0: return 9'h000; 1: return 9'h004; 2: return 9'h008; 3: return 9'h100;
      4: return 9'h104; 5: return 9'h00C; 6: return 9'h102;
      default: return 9'h180 + 9'(4 * $urandom_range(0, 15));
    endcase
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin : stim
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    rdConst(9'h000, 0, "R1 request");
    rdConst(9'h004, 0, "R1 enable");
    rdConst(9'h100, 0, "R1 detect");
    rdConst(9'h180, 0, "R1 cfg0");
    rdConst(9'h1AC, 0, "R1 cfg11");
    check("R1 irqOut", 32'(irqOut), 0);

    // R2: two-edge monitor latency
    pins[1] = 1'b1;
    @(negedge clk);
    rdConst(9'h104, 0, "R2 monitor after one edge");
    @(negedge clk);
    rdConst(9'h104, 32'h2, "R2 monitor after two edges");
    pins[1] = 1'b0;
    idle(3);

    // R3: config read-back and dropped slot
    wr(9'h1AC, 32'hABCD_EF00);
    rdConst(9'h1AC, 32'hABCD_EF00, "R3 cfg11 readback");
    wr(9'h1B0, 32'h0000_0005);
    rdConst(9'h1B0, 0, "R3 slot above line count");

    // R4: high level, clear while active
    wr(9'h180, 32'h02);
    wr(9'h008, 32'h1);
    pins[0] = 1'b1;
    idle(4);
    rdConst(9'h100, 32'h1, "R4 high level detected");
    check("R9 irqOut line0", 32'(irqOut), 32'h1);
    rdConst(9'h000, 32'h1, "R9 request line0");
    wr(9'h100, 32'h1);
    rdConst(9'h100, 32'h1, "R4 clear while high");
    pins[0] = 1'b0;
    idle(4);
    wr(9'h100, 32'h1);
    rdConst(9'h100, 0, "R4 clear after release");
    // R4: low level on line1 (pin low)
    wr(9'h184, 32'h01);
    idle(1);
    rdConst(9'h100, 32'h2, "R4 low level detected");
    wr(9'h184, 32'h00);
    wr(9'h100, 32'h2);
    idle(2);
    rdConst(9'h100, 0, "R6 sense zero idle");

    // R5: edge modes on line2
    wr(9'h188, 32'h08);
    pins[2] = 1'b1; idle(4);
    rdConst(9'h100, 32'h4, "R5 rising seen");
    wr(9'h100, 32'h4);
    pins[2] = 1'b0; idle(4);
    rdConst(9'h100, 0, "R5 falling ignored in rising mode");
    wr(9'h188, 32'h04);
    pins[2] = 1'b1; idle(4);
    rdConst(9'h100, 0, "R5 rising ignored in falling mode");
    pins[2] = 1'b0; idle(4);
    rdConst(9'h100, 32'h4, "R5 falling seen");
    wr(9'h100, 32'h4);
    wr(9'h188, 32'h0C);
    pins[2] = 1'b1; idle(4);
    rdConst(9'h100, 32'h4, "R5 both rising");
    wr(9'h100, 32'h4);
    pins[2] = 1'b0; idle(4);
    rdConst(9'h100, 32'h4, "R5 both falling");
    wr(9'h100, 32'h4);
    rdConst(9'h100, 0, "R7 clear edge");

    // R6: undefined codes
    wr(9'h18C, 32'h03);
    pins[3] = 1'b1; idle(4);
    pins[3] = 1'b0; idle(4);
    rdConst(9'h100, 0, "R6 code 0x03");
    wr(9'h18C, 32'hFFFF_FF10);
    pins[3] = 1'b1; idle(4);
    rdConst(9'h100, 0, "R6 code 0x10");
    pins[3] = 1'b0; idle(3);

    // R7: zero write keeps bits
    wr(9'h180, 32'h02);
    pins[0] = 1'b1; idle(4);
    pins[0] = 1'b0; idle(4);
    wr(9'h100, 32'h0);
    rdConst(9'h100, 32'h1, "R7 zero write keeps bit");
    wr(9'h100, 32'h1);
    rdConst(9'h100, 0, "R7 one write clears bit");

    // R8: enable set and clear
    wr(9'h008, 32'h0F0);
    rdConst(9'h004, 32'h0F1, "R8 enable set");
    wr(9'h004, 32'h011);
    rdConst(9'h004, 32'h0E0, "R8 enable clear");
    rdConst(9'h008, 0, "R8 set reg reads zero");
    wr(9'h008, 32'hFFFF_FFFF);
    rdConst(9'h004, 32'h0000_0FFF, "R10 enable upper bits zero");

    // R9: read-only words ignore writes
    wr(9'h000, 32'hFFFF_FFFF);
    wr(9'h104, 32'hFFFF_FFFF);
    rdModel(9'h000, "R9 request after write");
    rdModel(9'h100, "R9 detect after ro write");
    rdModel(9'h104, "R9 monitor after write");

    // R10: unmapped and unaligned
    rdConst(9'h00C, 0, "R10 unmapped");
    rdConst(9'h102, 0, "R10 unaligned");
    rdConst(9'h181, 0, "R10 unaligned cfg");

    // random phase
    for (int it = 0; it < 4000; it++) begin
      @(negedge clk);
      busWe = 1'b0;
      check("R9 irqOut", 32'(irqOut), 32'(mDet & mEn));
      if ($urandom_range(0, 3) == 0) pins = pins ^ N'(1 << $urandom_range(0, N-1));
      case ($urandom_range(0, 9))
        0, 1: begin
          busWe = 1'b1;
          busAddr = 9'h180 + 9'(4 * $urandom_range(0, 15));
          busWrData = ($urandom() & 32'hFFFF_FFC0) | 32'(pickSense());
        end
        2: begin busWe = 1'b1; busAddr = 9'h008; busWrData = $urandom(); end
        3: begin busWe = 1'b1; busAddr = 9'h004; busWrData = $urandom(); end
        4: begin busWe = 1'b1; busAddr = 9'h100; busWrData = $urandom(); end
        5: begin
          busWe = 1'b1;
          busAddr = ($urandom_range(0, 1) == 0) ? 9'h000 : 9'h104;
          busWrData = $urandom();
        end
        default: begin
          logic [8:0] a;
          a = pickReadAddr();
          rdModel(a, tagFor(a));
        end
      endcase
    end
    @(negedge clk);
    busWe = 1'b0;
    check("R9 irqOut final", 32'(irqOut), 32'(mDet & mEn));
    finishRun();
  end

endmodule